// File: doc/BRIEF.md
# Capture/Reload Timer with Serial Clock Output

A 16-bit timer/counter with a byte-wide register port. It advances either once per machine-cycle enable (timer function) or on falling edges of an external count pin (counter function). A second external pin, the trigger, can either snapshot the count into the capture/reload pair or force a reload from that pair. When the block is set to clock a serial port, its overflow pulses become the receive and/or transmit serial clock. In that setting the overflow flag is suppressed and the trigger is ignored.

Operation is governed by a mode state machine with four states:

- `M_IDLE`: run bit clear.
- `M_RELOAD`: run set, capture select clear, neither serial enable set.
- `M_CAPTURE`: run set, capture select set, neither serial enable set.
- `M_BAUD`: run set, at least one serial enable set.

Every write to the control register moves the machine to the state the written byte decodes to. The transitions run IDLE→RELOAD, IDLE→CAPTURE, IDLE→BAUD and back, plus RELOAD↔CAPTURE, RELOAD↔BAUD and CAPTURE↔BAUD. A write that decodes to the same state stays put. No other event changes the state.

The interrupt request is high while either flag is set. Both external pins are sampled on each machine-cycle enable. A falling edge is a 1 sample followed by a 0 sample.

Top module: `cap_reload_timer`

## Requirements
- R1: After reset, every register reads 0x00. This covers control, count low/high and capture low/high. `irq`, `rx_clk` (with `alt_ovf` low) and `tx_clk` are low.
- R2: In timer function (control bit 1 = 0) with run set (bit 2 = 1), the count rises by one on each cycle where `cyc_en` is high.
- R3: In counter function (bit 1 = 1), the count rises by one per falling edge of `cnt_pin`. `cnt_pin` is sampled only when `cyc_en` is high.
- R4: With run clear, the count and the capture pair hold their values and trigger edges have no effect.
- R5: In reload mode (bit 0 = 0, bits 5 and 4 = 0), an increment from 0xFFFF loads the count from the capture/reload pair and sets the overflow flag (bit 7).
- R6: In reload mode, a falling edge on `trig_pin` with external enable (bit 3) set loads the count from the pair and sets the external flag (bit 6). With bit 3 clear, the edge does nothing.
- R7: In capture mode (bit 0 = 1), a trigger edge with bit 3 set copies the current count into the pair and sets bit 6. The count keeps running, and an increment from 0xFFFF wraps to 0x0000 and sets bit 7.
- R8: With bit 5 (receive clock enable) or bit 4 (transmit clock enable) set, the count reloads on overflow whatever bit 0 holds. Bit 7 is never set, and trigger edges neither reload, capture nor set bit 6.
- R9: With bit 5 set, `rx_clk` pulses high for one cycle in the cycle after an overflow. With bit 5 clear, `rx_clk` follows `alt_ovf`. `tx_clk` behaves the same way under bit 4.
- R10: `irq` is high exactly while bit 7 or bit 6 is set. Both flags stay set until software writes the control register.
- R11: Register addresses are: 0 control, 1 count low, 2 count high, 3 capture/reload low, 4 capture/reload high. Addresses 5 to 7 read 0x00. A write takes effect at the clock edge and overrides any hardware update of the same register in that cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_en | input | 1 | Machine-cycle enable: timer tick and pin sampling strobe |
| cnt_pin | input | 1 | External count input (counter function) |
| trig_pin | input | 1 | External capture/reload trigger |
| alt_ovf | input | 1 | Overflow pulse of another timer, used as serial clock when an enable is clear |
| wr_en | input | 1 | Register write strobe |
| addr | input | 3 | Register address for read and write |
| wr_data | input | 8 | Write data |
| rd_data | output | 8 | Read data for `addr` (combinational) |
| irq | output | 1 | Interrupt request |
| rx_clk | output | 1 | Receive serial clock pulse |
| tx_clk | output | 1 | Transmit serial clock pulse |

## Verification
The count is driven in four patterns, and each one separates behaviours the others cannot:

- **Steady machine-cycle ticks from a preset near 0xFFFF.** This separates reload from wrap and shows when the flag is set.
- **Toggled count pin held across several enables.** This shows that edges, not levels, are counted, and only on sampling cycles.
- **Trigger edges with external enable on, then off, in each of the three modes.** This tells capture from reload from ignore.
- **Serial-clock mode with the capture select set and a toggling alternate overflow.** This shows that the capture select is overridden, the overflow flag stays clear, and each serial clock picks its own source.

A behavioural model in the bench predicts read data, `irq` and both serial clocks every cycle.

// File: rtl/tmr_pkg.sv
package tmr_pkg;

    localparam int BIT_TF     = 7;
    localparam int BIT_EXF    = 6;
    localparam int BIT_RXEN   = 5;
    localparam int BIT_TXEN   = 4;
    localparam int BIT_EXEN   = 3;
    localparam int BIT_RUN    = 2;
    localparam int BIT_CNTSEL = 1;
    localparam int BIT_CAPSEL = 0;

    localparam int ADDR_W = 3;
    localparam logic [ADDR_W-1:0] A_CTRL   = 3'd0;
    localparam logic [ADDR_W-1:0] A_CNT_LO = 3'd1;
    localparam logic [ADDR_W-1:0] A_CNT_HI = 3'd2;
    localparam logic [ADDR_W-1:0] A_CAP_LO = 3'd3;
    localparam logic [ADDR_W-1:0] A_CAP_HI = 3'd4;

    typedef enum logic [1:0] {
        M_IDLE,
        M_RELOAD,
        M_CAPTURE,
        M_BAUD
    } tmr_mode_e;

    typedef struct packed {
        logic count_en;
        logic reload_ovf;
        logic reload_trig;
        logic capture_trig;
        logic flag_ovf;
        logic baud_pulse;
    } tmr_ctl_t;

    function automatic tmr_mode_e mode_of(input logic [7:0] c);
        if (!c[BIT_RUN])
            return M_IDLE;
        else if (c[BIT_RXEN] || c[BIT_TXEN])
            return M_BAUD;
        else if (c[BIT_CAPSEL])
            return M_CAPTURE;
        else
            return M_RELOAD;
    endfunction

endpackage

// File: rtl/tmr_fall_det.sv
module tmr_fall_det (
    input  logic clk,
    input  logic rst_n,
    input  logic sample_en,
    input  logic pin,
    output logic fall
);

    logic last_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            last_q <= 1'b0;
        else if (sample_en)
            last_q <= pin;
    end

    // a 1 sample followed by a 0 sample on the same strobe
    assign fall = sample_en & last_q & ~pin;

endmodule

// File: rtl/tmr_count_core.sv
module tmr_count_core
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  tmr_ctl_t            ctl,
    input  logic                tick,
    input  logic                trig_evt,
    input  logic                wr_cnt_lo,
    input  logic                wr_cnt_hi,
    input  logic                wr_cap_lo,
    input  logic                wr_cap_hi,
    input  logic [DATA_W-1:0]   wr_data,
    output logic [2*DATA_W-1:0] cnt,
    output logic [2*DATA_W-1:0] cap,
    output logic                ovf_evt,
    output logic                trig_hit
);

    localparam int CNT_W = 2 * DATA_W;

    logic [CNT_W-1:0] cnt_q, cnt_d;
    logic [CNT_W-1:0] cap_q, cap_d;
    logic             step;
    logic             do_reload;
    logic             do_capture;

    assign step       = ctl.count_en & tick;
    assign ovf_evt    = step & (cnt_q == {CNT_W{1'b1}});
    assign do_capture = trig_evt & ctl.capture_trig;
    assign do_reload  = (ovf_evt & ctl.reload_ovf) | (trig_evt & ctl.reload_trig);
    assign trig_hit   = trig_evt & (ctl.reload_trig | ctl.capture_trig);

    always_comb begin
        cnt_d = cnt_q;
        if (wr_cnt_lo)
            cnt_d = {cnt_q[CNT_W-1:DATA_W], wr_data};
        else if (wr_cnt_hi)
            cnt_d = {wr_data, cnt_q[DATA_W-1:0]};
        else if (do_reload)
            cnt_d = cap_q;
        else if (step)
            cnt_d = cnt_q + 1'b1;
    end

    always_comb begin
        cap_d = cap_q;
        if (wr_cap_lo)
            cap_d = {cap_q[CNT_W-1:DATA_W], wr_data};
        else if (wr_cap_hi)
            cap_d = {wr_data, cap_q[DATA_W-1:0]};
        else if (do_capture)
            cap_d = cnt_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
            cap_q <= '0;
        end else begin
            cnt_q <= cnt_d;
            cap_q <= cap_d;
        end
    end

    assign cnt = cnt_q;
    assign cap = cap_q;

endmodule

// File: rtl/cap_reload_timer.sv
module cap_reload_timer
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cyc_en,
    input  logic              cnt_pin,
    input  logic              trig_pin,
    input  logic              alt_ovf,
    input  logic              wr_en,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic [DATA_W-1:0] rd_data,
    output logic              irq,
    output logic              rx_clk,
    output logic              tx_clk
);

    localparam int CNT_W = 2 * DATA_W;

    tmr_mode_e         mode_q, mode_d;
    tmr_ctl_t          ctl;
    logic [DATA_W-1:0] ctrl_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  cap_q;
    logic              cnt_fall;
    logic              trig_fall;
    logic              tick;
    logic              ovf_evt;
    logic              trig_hit;
    logic              ovf_pulse_q;
    logic              ctrl_wr;

    assign ctrl_wr = wr_en && (addr == A_CTRL);

    // ---- pin edge detectors, one per external pin ----
    tmr_fall_det u_cnt_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (cyc_en),
        .pin       (cnt_pin),
        .fall      (cnt_fall)
    );

    tmr_fall_det u_trig_edge (
        .clk       (clk),
        .rst_n     (rst_n),
        .sample_en (cyc_en),
        .pin       (trig_pin),
        .fall      (trig_fall)
    );

    // ---- mode state machine: state register ----
    always_comb begin
        mode_d = mode_q;
        if (ctrl_wr)
            mode_d = mode_of(wr_data);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            mode_q <= M_IDLE;
        else
            mode_q <= mode_d;
    end

    // ---- mode state machine: outputs ----
    always_comb begin
        ctl = '0;
        unique case (mode_q)
            M_IDLE: begin
                ctl = '0;
            end
            M_RELOAD: begin
                ctl.count_en    = 1'b1;
                ctl.reload_ovf  = 1'b1;
                ctl.reload_trig = ctrl_q[BIT_EXEN];
                ctl.flag_ovf    = 1'b1;
            end
            M_CAPTURE: begin
                ctl.count_en     = 1'b1;
                ctl.capture_trig = ctrl_q[BIT_EXEN];
                ctl.flag_ovf     = 1'b1;
            end
            M_BAUD: begin
                ctl.count_en   = 1'b1;
                ctl.reload_ovf = 1'b1;
                ctl.baud_pulse = 1'b1;
            end
        endcase
    end

    assign tick = ctrl_q[BIT_CNTSEL] ? cnt_fall : cyc_en;

    // ---- counting datapath ----
    tmr_count_core #(.DATA_W(DATA_W)) u_core (
        .clk       (clk),
        .rst_n     (rst_n),
        .ctl       (ctl),
        .tick      (tick),
        .trig_evt  (trig_fall),
        .wr_cnt_lo (wr_en && (addr == A_CNT_LO)),
        .wr_cnt_hi (wr_en && (addr == A_CNT_HI)),
        .wr_cap_lo (wr_en && (addr == A_CAP_LO)),
        .wr_cap_hi (wr_en && (addr == A_CAP_HI)),
        .wr_data   (wr_data),
        .cnt       (cnt_q),
        .cap       (cap_q),
        .ovf_evt   (ovf_evt),
        .trig_hit  (trig_hit)
    );

    // ---- control register with sticky flags ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            ctrl_q <= '0;
        end else if (ctrl_wr) begin
            ctrl_q <= wr_data;
        end else begin
            if (ovf_evt && ctl.flag_ovf)
                ctrl_q[BIT_TF] <= 1'b1;
            if (trig_hit)
                ctrl_q[BIT_EXF] <= 1'b1;
        end
    end

    // ---- serial clock pulse ----
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            ovf_pulse_q <= 1'b0;
        else
            ovf_pulse_q <= ovf_evt & ctl.baud_pulse;
    end

    assign rx_clk = ctrl_q[BIT_RXEN] ? ovf_pulse_q : alt_ovf;
    assign tx_clk = ctrl_q[BIT_TXEN] ? ovf_pulse_q : alt_ovf;
    assign irq    = ctrl_q[BIT_TF] | ctrl_q[BIT_EXF];

    // ---- read mux ----
    always_comb begin
        unique case (addr)
            A_CTRL:   rd_data = ctrl_q;
            A_CNT_LO: rd_data = cnt_q[DATA_W-1:0];
            A_CNT_HI: rd_data = cnt_q[CNT_W-1:DATA_W];
            A_CAP_LO: rd_data = cap_q[DATA_W-1:0];
            A_CAP_HI: rd_data = cap_q[CNT_W-1:DATA_W];
            default:  rd_data = '0;
        endcase
    end

endmodule

// File: rtl/tmr_checker.sv
module tmr_checker
    import tmr_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input logic                clk,
    input logic                rst_n,
    input logic                wr_en,
    input logic [ADDR_W-1:0]   addr,
    input logic [DATA_W-1:0]   ctrl,
    input logic [2*DATA_W-1:0] cnt,
    input logic [2*DATA_W-1:0] cap,
    input tmr_mode_e           mode,
    input logic                trig_fall,
    input logic                rx_clk,
    input logic                tx_clk
);

    // R8: serial-clock mode never raises the overflow flag
    p_baud_no_tf_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_BAUD && !(wr_en && addr == A_CTRL)) |=> !$rose(ctrl[BIT_TF]));

    // R4: stopped timer holds count and capture pair
    p_idle_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_IDLE && !wr_en) |=> ($stable(cnt) && $stable(cap)));

    // R7: trigger edge in capture mode snapshots the count and flags it
    p_capture_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == M_CAPTURE && ctrl[BIT_EXEN] && trig_fall && !wr_en)
        |=> (cap == $past(cnt) && ctrl[BIT_EXF]));

    // R9: an internal receive clock pulse only follows an all-ones count
    p_rx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[BIT_RXEN] && rx_clk) |-> ($past(cnt) == {2*DATA_W{1'b1}}));

    // R9: same for the transmit clock
    p_tx_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[BIT_TXEN] && tx_clk) |-> ($past(cnt) == {2*DATA_W{1'b1}}));

    // R10: overflow flag is sticky until a control write
    p_tf_sticky_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl[BIT_TF] && !(wr_en && addr == A_CTRL)) |=> ctrl[BIT_TF]);

endmodule

bind cap_reload_timer tmr_checker #(.DATA_W(DATA_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .wr_en     (wr_en),
    .addr      (addr),
    .ctrl      (ctrl_q),
    .cnt       (cnt_q),
    .cap       (cap_q),
    .mode      (mode_q),
    .trig_fall (trig_fall),
    .rx_clk    (rx_clk),
    .tx_clk    (tx_clk)
);

// File: tb/tb_cap_reload_timer.sv
module tb_cap_reload_timer;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cyc_en = 1'b0;
    logic       cnt_pin = 1'b0;
    logic       trig_pin = 1'b0;
    logic       alt_ovf = 1'b0;
    logic       wr_en = 1'b0;
    logic [2:0] addr = 3'd0;
    logic [7:0] wr_data = 8'd0;
    logic [7:0] rd_data;
    logic       irq, rx_clk, tx_clk;

    int checks = 0;
    int errors = 0;
    bit done = 0;
    string cur_req = "R1";

    always #5 clk = ~clk;

    cap_reload_timer dut (
        .clk(clk), .rst_n(rst_n), .cyc_en(cyc_en), .cnt_pin(cnt_pin),
        .trig_pin(trig_pin), .alt_ovf(alt_ovf), .wr_en(wr_en), .addr(addr),
        .wr_data(wr_data), .rd_data(rd_data), .irq(irq),
        .rx_clk(rx_clk), .tx_clk(tx_clk)
    );

    // machine-cycle strobe every second clock
    int ph = 0;
    always @(negedge clk) begin
        ph = (ph + 1) % 2;
        cyc_en = (ph == 0);
    end

    // ---------------- behavioural reference model ----------------
    int m_cnt, m_cap, m_ctrl, m_pc, m_pt, m_pulse;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_cnt = 0; m_cap = 0; m_ctrl = 0; m_pc = 0; m_pt = 0; m_pulse = 0;
        end else begin
            int ncnt, ncap, nctrl;
            bit fc, ft, run, baud, exen, tk, ov, tedge;
            fc = cyc_en && m_pc == 1 && !cnt_pin;
            ft = cyc_en && m_pt == 1 && !trig_pin;
            if (cyc_en) begin m_pc = cnt_pin; m_pt = trig_pin; end
            run  = m_ctrl[2];
            baud = m_ctrl[5] || m_ctrl[4];
            exen = m_ctrl[3];
            tk   = run && (m_ctrl[1] ? fc : cyc_en);
            ov   = tk && m_cnt == 65535;
            tedge = ft && exen;
            ncnt = m_cnt; ncap = m_cap; nctrl = m_ctrl;
            if (run) begin
                if (baud) begin
                    if (ov) ncnt = m_cap; else if (tk) ncnt = m_cnt + 1;
                end else if (m_ctrl[0]) begin
                    if (tk) ncnt = (m_cnt + 1) % 65536;
                    if (ov) nctrl = nctrl | 8'h80;
                    if (tedge) begin ncap = m_cnt; nctrl = nctrl | 8'h40; end
                end else begin
                    if (ov || tedge) ncnt = m_cap; else if (tk) ncnt = m_cnt + 1;
                    if (ov) nctrl = nctrl | 8'h80;
                    if (tedge) nctrl = nctrl | 8'h40;
                end
            end
            m_pulse = (run && baud && ov) ? 1 : 0;
            if (wr_en) begin
                case (addr)
                    3'd0: nctrl = wr_data;
                    3'd1: ncnt = (m_cnt & 16'hFF00) | wr_data;
                    3'd2: ncnt = (m_cnt & 16'h00FF) | (int'(wr_data) << 8);
                    3'd3: ncap = (m_cap & 16'hFF00) | wr_data;
                    3'd4: ncap = (m_cap & 16'h00FF) | (int'(wr_data) << 8);
                    default: ;
                endcase
            end
            m_cnt = ncnt; m_cap = ncap; m_ctrl = nctrl;
        end
    end

    function automatic int exp_rd(input logic [2:0] a);
        case (a)
            3'd0: return m_ctrl;
            3'd1: return m_cnt & 255;
            3'd2: return (m_cnt >> 8) & 255;
            3'd3: return m_cap & 255;
            3'd4: return (m_cap >> 8) & 255;
            default: return 0;
        endcase
    endfunction

    task automatic chk(input int act, input int exp, input string what);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s actual=%0h expected=%0h at %0t", cur_req, what, act, exp, $time);
        end
    endtask

    // every-clock comparison against the model
    always @(posedge clk) begin
        #2;
        if (rst_n && !done) begin
            chk(int'(rd_data), exp_rd(addr), "rd_data");
            chk(int'(irq), (m_ctrl[7] || m_ctrl[6]) ? 1 : 0, "irq (R10)");
            chk(int'(rx_clk), m_ctrl[5] ? m_pulse : int'(alt_ovf), "rx_clk (R9)");
            chk(int'(tx_clk), m_ctrl[4] ? m_pulse : int'(alt_ovf), "tx_clk (R9)");
        end
    end

    // ---------------- stimulus helpers ----------------
    task automatic wr(input logic [2:0] a, input logic [7:0] d);
        @(negedge clk); wr_en = 1'b1; addr = a; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic idle(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic rd_get(input logic [2:0] a, output int v);
        @(negedge clk); addr = a;
        @(posedge clk); #2; v = rd_data;
    endtask

    task automatic set16(input logic [2:0] lo, input int v);
        wr(lo + 3'd1, 8'((v >> 8) & 255));
        wr(lo, 8'(v & 255));
    endtask

    task automatic trig_pulses(input int n);
        for (int i = 0; i < n; i++) begin
            trig_pin = 1'b1; idle(5);
            trig_pin = 1'b0; idle(5);
        end
    endtask

    initial begin
        int v, v2;
        idle(3);
        rst_n = 1'b1;

        // R1: reset values on every register and output
        cur_req = "R1";
        for (int a = 0; a < 5; a++) begin
            rd_get(3'(a), v);
            chk(v, 0, "reset read");
        end
        chk(int'(irq), 0, "reset irq");
        chk(int'(tx_clk), 0, "reset tx_clk");

        // R2: timer function counts machine cycles
        cur_req = "R2";
        set16(3'd1, 16'h0010);
        wr(3'd0, 8'h04);
        idle(20);
        rd_get(3'd1, v);
        chk(int'(v > 16'h10), 1, "count advanced");

        // R5: reload on overflow sets the overflow flag
        cur_req = "R5";
        wr(3'd0, 8'h00);
        set16(3'd3, 16'h1234);
        set16(3'd1, 16'hFFFC);
        wr(3'd0, 8'h04);
        idle(14);
        rd_get(3'd2, v);
        chk(v, 8'h12, "reloaded high byte");
        cur_req = "R10";
        chk(int'(irq), 1, "irq after overflow");
        idle(6);
        chk(int'(irq), 1, "flag sticky");
        wr(3'd0, 8'h04);
        idle(1);
        chk(int'(irq), 0, "flag cleared by write");

        // R6: trigger reload with and without external enable
        cur_req = "R6";
        trig_pulses(2);
        set16(3'd1, 16'h0100);
        wr(3'd0, 8'h0C);
        trig_pulses(3);
        rd_get(3'd0, v);
        chk(v & 8'h40, 8'h40, "external flag set");

        // R7: capture mode
        cur_req = "R7";
        wr(3'd0, 8'h00);
        set16(3'd3, 16'h0000);
        set16(3'd1, 16'hFFE0);
        wr(3'd0, 8'h0D);
        trig_pulses(2);
        idle(60);
        rd_get(3'd0, v);
        chk(v & 8'hC0, 8'hC0, "both flags after capture and wrap");
        rd_get(3'd4, v);
        chk(int'(v == 8'hFF), 1, "captured high byte");

        // R3: counter function on count-pin edges
        cur_req = "R3";
        wr(3'd0, 8'h00);
        set16(3'd1, 16'h0000);
        wr(3'd0, 8'h06);
        for (int i = 0; i < 6; i++) begin
            cnt_pin = 1'b1; idle(4);
            cnt_pin = 1'b0; idle(4);
        end
        idle(2);
        rd_get(3'd1, v);
        chk(int'(v >= 5 && v <= 6), 1, "edge count");

        // R4: stopped timer ignores ticks and triggers
        cur_req = "R4";
        wr(3'd0, 8'h09);
        rd_get(3'd1, v);
        trig_pulses(3);
        cnt_pin = 1'b1; idle(4); cnt_pin = 1'b0; idle(4);
        rd_get(3'd1, v2);
        chk(v2, v, "count held");
        rd_get(3'd0, v2);
        chk(v2 & 8'h40, 0, "no external flag while stopped");

        // R8 / R9: serial clock mode with capture select set
        cur_req = "R8";
        set16(3'd3, 16'hFFF8);
        set16(3'd1, 16'hFFF8);
        wr(3'd0, 8'h3D);
        for (int i = 0; i < 20; i++) begin
            alt_ovf = ~alt_ovf;
            trig_pin = i[1];
            idle(3);
        end
        rd_get(3'd0, v);
        chk(v & 8'hC0, 0, "no flags in serial clock mode");
        rd_get(3'd4, v);
        chk(v, 8'hFF, "pair untouched by triggers");

        cur_req = "R9";
        wr(3'd0, 8'h24);
        for (int i = 0; i < 20; i++) begin
            alt_ovf = ~alt_ovf;
            idle(3);
        end
        alt_ovf = 1'b1; idle(1);
        chk(int'(tx_clk), 1, "tx follows alternate source");

        // R11: unmapped addresses and write priority
        cur_req = "R11";
        rd_get(3'd6, v);
        chk(v, 0, "unmapped read");
        wr(3'd0, 8'h00);
        set16(3'd1, 16'hABCD);
        rd_get(3'd2, v);
        chk(v, 8'hAB, "count high write");

        idle(4);
        done = 1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        #(200000 * 10);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog %s actual=running expected=finished", cur_req);
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule